// File: doc/BRIEF.md
# Keyed SHA-1 Digest Engine

This block produces a keyed fingerprint of a 160-bit challenge so that a host can tell a genuine accessory from a copy. Software loads the challenge one byte at a time into a 20-byte message space, then sets the start bit in an 8-bit control register. The engine hashes the 128-bit device key followed by the challenge. It then hashes the key again, this time followed by that first result. The final 160-bit value replaces the challenge in the same byte space, and a completion flag rises.

Both passes fit in a single 512-bit SHA-1 block. Each block carries the 288 data bits, one set bit, 159 zero bits and a 64-bit length field of 288. A single compression core, which runs one round per clock, serves both passes in turn. The control register also holds a self-clearing wipe command for the message space and a sticky power-on flag that software can only clear. Reads of both the control register and the message space return data one clock after the request, from registers.

Top module: `keyed_digest_engine`

## Requirements
- R1: After reset the control register reads 0x04 (only the power-on flag set) and all 20 message bytes read 0x00.
- R2: A message write while idle to byte address 0..19 stores the byte, and it reads back from that address one clock after the address is presented. Address 19 is the most significant byte of the 160-bit value M and address 0 the least. Writes to addresses 20 and above are dropped, and those addresses read 0x00.
- R3: On completion the message space holds SHA1(K || SHA1(K || M)). Each pass hashes one block {K, data, 1, 159 zeros, 64-bit 288}, starting from the standard SHA-1 initial values. Digest word A goes to bytes 19..16 (A[31:24] at 19) and word E to bytes 3..0.
- R4: Writing 1 to control bit 0 (AUTH) while idle starts a job and clears bit 1 (DONE). From then until completion the register reads 0x01 in its low two bits.
- R5: At completion AUTH returns to 0 and DONE to 1. The register shows this no more than 200 clocks after the edge that accepted the start write.
- R6: Writing 1 to control bit 4 (CLEAR) while idle sets all 20 message bytes to 0x00. Bit 4 always reads 0.
- R7: Control bit 2 (power-on flag) is cleared by any control write with bit 2 = 0. A write with bit 2 = 1 leaves it unchanged, and once cleared it never sets again.
- R8: While a job runs, message writes, CLEAR and further AUTH writes are ignored, and the message bytes keep their pre-job values until the result is written back.
- R9: Control bits 7, 6, 5 and 3 always read 0, and a write to DONE does not change it.
- R10: Jobs can be chained. A second AUTH with no new message hashes the previous digest, and a new key value on the key input is used by the next job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | KEY_W (128) | Device key, held stable during a job |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Registered control register value |
| msg_we | input | 1 | Message byte write strobe |
| msg_addr | input | 5 | Message byte address (read and write) |
| msg_wdata | input | 8 | Message byte write data |
| msg_rdata | output | 8 | Registered message byte at msg_addr |

## Verification
The hardest case to reach is a write that arrives in the middle of the roughly 168-clock job. The job holds the message bytes it started from. A stray write or wipe must leave them untouched until the write-back, and the write-back then overwrites every byte, which hides any earlier damage. The bench therefore issues a message write and a combined CLEAR/AUTH write just after a start. While the job is still running, it reads the whole message space back and the control register. It then lets the job finish and compares the result with a behavioural two-pass SHA-1 model. Chained jobs start from a DONE=1 state, which shows that starting a job clears the flag.

// File: rtl/keyed_digest_pkg.sv
package keyed_digest_pkg;
  localparam int DIG_W     = 160;
  localparam int DIG_BYTES = DIG_W / 8;
  localparam int ADDR_W    = $clog2(DIG_BYTES);
  localparam int BLK_W     = 512;
  localparam int LEN_W     = 64;
  localparam int WORD_W    = 32;

  // control register bit positions
  localparam int CB_AUTH  = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_POR   = 2;
  localparam int CB_CLEAR = 4;

  localparam logic [31:0] IV0 = 32'h67452301;
  localparam logic [31:0] IV1 = 32'hEFCDAB89;
  localparam logic [31:0] IV2 = 32'h98BADCFE;
  localparam logic [31:0] IV3 = 32'h10325476;
  localparam logic [31:0] IV4 = 32'hC3D2E1F0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD1, ST_RUN1, ST_LOAD2, ST_RUN2, ST_WB
  } seq_state_t;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction
endpackage

// File: rtl/sha1_round_core.sv
module sha1_round_core import keyed_digest_pkg::*; #(
  parameter int ROUNDS = 80,
  parameter int WIN    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] block,
  output logic [DIG_W-1:0] digest,
  output logic             dvalid
);
  localparam int RW = $clog2(ROUNDS);
  localparam int IW = $clog2(WIN);

  logic [31:0]   wbuf [WIN];
  logic [31:0]   a, b, c, d, e;
  logic [RW-1:0] rnd;
  logic          running, fin;
  logic [IW-1:0] idx;
  logic [31:0]   wt, f, k, temp;

  always_comb begin
    idx = rnd[IW-1:0];
    if (rnd < RW'(WIN)) wt = wbuf[idx];
    else wt = rotl(wbuf[idx + IW'(13)] ^ wbuf[idx + IW'(8)] ^
                   wbuf[idx + IW'(2)] ^ wbuf[idx], 1);
    if (rnd < RW'(20)) begin
      f = (b & c) | (~b & d);       k = 32'h5A827999;
    end else if (rnd < RW'(40)) begin
      f = b ^ c ^ d;                k = 32'h6ED9EBA1;
    end else if (rnd < RW'(60)) begin
      f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC;
    end else begin
      f = b ^ c ^ d;                k = 32'hCA62C1D6;
    end
    temp = rotl(a, 5) + f + e + k + wt;
  end

  // sequencing state, reset
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      fin     <= 1'b0;
      dvalid  <= 1'b0;
      rnd     <= '0;
    end else begin
      dvalid <= 1'b0;
      if (start) begin
        running <= 1'b1;
        fin     <= 1'b0;
        rnd     <= '0;
      end else if (running) begin
        rnd <= rnd + RW'(1);
        if (rnd == RW'(ROUNDS - 1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end else if (fin) begin
        fin    <= 1'b0;
        dvalid <= 1'b1;
      end
    end
  end

  // datapath, no reset
  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < WIN; i++) wbuf[i] <= block[BLK_W-1-WORD_W*i -: WORD_W];
      a <= IV0; b <= IV1; c <= IV2; d <= IV3; e <= IV4;
    end else if (running) begin
      wbuf[idx] <= wt;
      e <= d;
      d <= c;
      c <= rotl(b, 30);
      b <= a;
      a <= temp;
    end else if (fin) begin
      digest <= {IV0 + a, IV1 + b, IV2 + c, IV3 + d, IV4 + e};
    end
  end
endmodule

// File: rtl/digest_sequencer.sv
module digest_sequencer import keyed_digest_pkg::*; #(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [KEY_W-1:0] key,
  input  logic [DIG_W-1:0] msg,
  input  logic [DIG_W-1:0] core_digest,
  input  logic             core_dvalid,
  output logic             core_start,
  output logic [BLK_W-1:0] core_block,
  output logic             busy,
  output logic             wb_en
);
  localparam int DATA_BITS = KEY_W + DIG_W;
  localparam int PAD_ZEROS = BLK_W - LEN_W - 1 - DATA_BITS;

  seq_state_t state, nxt;

  function automatic logic [BLK_W-1:0] pad_blk(input logic [KEY_W-1:0] kk,
                                               input logic [DIG_W-1:0] dd);
    return {kk, dd, 1'b1, {PAD_ZEROS{1'b0}}, LEN_W'(DATA_BITS)};
  endfunction

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (go) nxt = ST_LOAD1;
      ST_LOAD1: nxt = ST_RUN1;
      ST_RUN1:  if (core_dvalid) nxt = ST_LOAD2;
      ST_LOAD2: nxt = ST_RUN2;
      ST_RUN2:  if (core_dvalid) nxt = ST_WB;
      ST_WB:    nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign core_start = (state == ST_LOAD1) || (state == ST_LOAD2);
  assign core_block = pad_blk(key, (state == ST_LOAD2) ? core_digest : msg);
  assign busy       = (state != ST_IDLE);
  assign wb_en      = (state == ST_WB);
endmodule

// File: rtl/keyed_digest_engine.sv
module keyed_digest_engine import keyed_digest_pkg::*; #(
  parameter int KEY_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic              msg_we,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [7:0]        msg_wdata,
  output logic [7:0]        msg_rdata
);
  logic [7:0]       mem [DIG_BYTES];
  logic [DIG_W-1:0] msg_flat;
  logic             auth_q, done_q, por_q;
  logic             busy, go, clr_go, wr_ok, in_range, wb_en;
  logic             core_start, core_dvalid;
  logic [BLK_W-1:0] core_block;
  logic [DIG_W-1:0] core_digest;
  logic             unused_wbits;

  assign unused_wbits = ^{ctrl_wdata[7:5], ctrl_wdata[3], ctrl_wdata[CB_DONE]};

  always_comb begin
    for (int i = 0; i < DIG_BYTES; i++) msg_flat[8*i +: 8] = mem[i];
  end

  assign in_range = (msg_addr < ADDR_W'(DIG_BYTES));
  assign go       = ctrl_we && ctrl_wdata[CB_AUTH]  && !busy;
  assign clr_go   = ctrl_we && ctrl_wdata[CB_CLEAR] && !busy;
  assign wr_ok    = msg_we && in_range && !busy;

  digest_sequencer #(.KEY_W(KEY_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .key(key_in), .msg(msg_flat),
    .core_digest(core_digest), .core_dvalid(core_dvalid),
    .core_start(core_start), .core_block(core_block),
    .busy(busy), .wb_en(wb_en)
  );

  sha1_round_core u_core (
    .clk(clk), .rst(rst), .start(core_start), .block(core_block),
    .digest(core_digest), .dvalid(core_dvalid)
  );

  // message / digest byte space
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DIG_BYTES; i++) mem[i] <= 8'h00;
    end else if (wb_en) begin
      for (int i = 0; i < DIG_BYTES; i++) mem[i] <= core_digest[8*i +: 8];
    end else if (clr_go) begin
      for (int i = 0; i < DIG_BYTES; i++) mem[i] <= 8'h00;
    end else if (wr_ok) begin
      mem[msg_addr] <= msg_wdata;
    end
  end

  // control flags
  always_ff @(posedge clk) begin
    if (rst) begin
      auth_q <= 1'b0;
      done_q <= 1'b0;
      por_q  <= 1'b1;
    end else begin
      if (go) begin
        auth_q <= 1'b1;
        done_q <= 1'b0;
      end else if (wb_en) begin
        auth_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (ctrl_we && !ctrl_wdata[CB_POR]) por_q <= 1'b0;
    end
  end

  // registered read ports
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_rdata <= 8'h04;
      msg_rdata  <= 8'h00;
    end else begin
      ctrl_rdata <= {5'b00000, por_q, done_q, auth_q};
      msg_rdata  <= in_range ? mem[msg_addr] : 8'h00;
    end
  end
endmodule

// File: rtl/keyed_digest_chk.sv
module keyed_digest_chk import keyed_digest_pkg::*; #(
  parameter int MAX_LAT = 200
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_we,
  input logic             auth_bit,
  input logic [7:0]       ctrl_rdata,
  input logic             busy,
  input logic [DIG_W-1:0] msg_flat
);
  int lat_cnt;

  always_ff @(posedge clk) begin
    if (rst)       lat_cnt <= 0;
    else if (busy) lat_cnt <= lat_cnt + 1;
    else           lat_cnt <= 0;
  end

  // R5
  lat_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lat_cnt < MAX_LAT));

  // R4
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && auth_bit && !busy) |=> busy);

  // R4
  busy_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (ctrl_rdata[1:0] == 2'b01));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[7:3] == 5'b00000);

  // R7
  por_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rdata[2] |=> !ctrl_rdata[2]);

  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(msg_flat) || !busy));
endmodule

bind keyed_digest_engine keyed_digest_chk #(.MAX_LAT(200)) u_chk (
  .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .auth_bit(ctrl_wdata[0]),
  .ctrl_rdata(ctrl_rdata), .busy(busy), .msg_flat(msg_flat)
);

// File: tb/tb_keyed_digest_engine.sv
`timescale 1ns/1ps
module tb_keyed_digest_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] key_in = '0;
  logic         ctrl_we = 1'b0;
  logic [7:0]   ctrl_wdata = '0;
  logic [7:0]   ctrl_rdata;
  logic         msg_we = 1'b0;
  logic [4:0]   msg_addr = '0;
  logic [7:0]   msg_wdata = '0;
  logic [7:0]   msg_rdata;

  int           checks = 0;
  int           fails = 0;
  longint       cyc = 0;
  logic [159:0] mdl_msg = '0;

  keyed_digest_engine dut (
    .clk(clk), .rst(rst), .key_in(key_in), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .msg_we(msg_we),
    .msg_addr(msg_addr), .msg_wdata(msg_wdata), .msg_rdata(msg_rdata)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural SHA-1 with a full 80-word schedule
  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_sha1(input logic [511:0] blk);
    logic [31:0] w[80];
    logic [31:0] h[5];
    logic [31:0] va, vb, vc, vd, ve, f, k, t;
    h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
    h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
    for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rol(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    va = h[0]; vb = h[1]; vc = h[2]; vd = h[3]; ve = h[4];
    for (int i = 0; i < 80; i++) begin
      case (i / 20)
        0: begin f = (vb & vc) | (~vb & vd); k = 32'h5A827999; end
        1: begin f = vb ^ vc ^ vd; k = 32'h6ED9EBA1; end
        2: begin f = (vb & vc) | (vb & vd) | (vc & vd); k = 32'h8F1BBCDC; end
        default: begin f = vb ^ vc ^ vd; k = 32'hCA62C1D6; end
      endcase
      t = rol(va, 5) + f + ve + k + w[i];
      ve = vd; vd = vc; vc = rol(vb, 30); vb = va; va = t;
    end
    return {h[0] + va, h[1] + vb, h[2] + vc, h[3] + vd, h[4] + ve};
  endfunction

  function automatic logic [511:0] ref_pad(input logic [127:0] kk, input logic [159:0] dd);
    return {kk, dd, 1'b1, 159'd0, 64'd288};
  endfunction

  function automatic logic [159:0] ref_keyed(input logic [127:0] kk, input logic [159:0] m);
    return ref_sha1(ref_pad(kk, ref_sha1(ref_pad(kk, m))));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [159:0] act,
                     input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic wr_msg(input logic [4:0] a, input logic [7:0] v);
    msg_we = 1'b1; msg_addr = a; msg_wdata = v;
    @(negedge clk);
    msg_we = 1'b0;
  endtask

  task automatic rd_msg(input logic [4:0] a, output logic [7:0] v);
    msg_addr = a;
    @(negedge clk);
    v = msg_rdata;
  endtask

  task automatic rd_all(output logic [159:0] v);
    logic [7:0] b;
    for (int i = 0; i < 20; i++) begin
      rd_msg(5'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic rd_ctrl(output logic [7:0] v);
    @(negedge clk);
    v = ctrl_rdata;
  endtask

  task automatic run_job(input bit disturb, input string tag);
    logic [159:0] exp, got;
    logic [7:0]   c;
    longint       t0;
    bit           bad;
    exp = ref_keyed(key_in, mdl_msg);
    wr_ctrl(8'h01);
    t0 = cyc;
    if (disturb) begin
      wr_msg(5'd3, ~mdl_msg[31:24]);
      wr_ctrl(8'h11);
      rd_ctrl(c);
      chk(c == 8'h01, "R4 busy reads AUTH only", 160'(c), 160'h01);
      rd_all(got);
      chk(got == mdl_msg, "R8 message held during job", got, mdl_msg);
    end
    @(negedge clk);
    bad = 1'b0;
    while (!ctrl_rdata[1] && (cyc - t0) < 400) begin
      if (ctrl_rdata != 8'h01) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R4 flags while busy", 160'(ctrl_rdata), 160'h01);
    chk((cyc - t0) <= 200, "R5 completion latency", 160'(cyc - t0), 160'd200);
    chk(ctrl_rdata == 8'h02, "R5 flags at completion", 160'(ctrl_rdata), 160'h02);
    rd_all(got);
    chk(got == exp, tag, got, exp);
    mdl_msg = exp;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [159:0] v;
    logic [7:0]   b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(ctrl_rdata == 8'h04, "R1 control reset", 160'(ctrl_rdata), 160'h04);
    rd_all(v);
    chk(v == '0, "R1 message reset", v, '0);

    // R2 byte writes and readback
    for (int i = 0; i < 20; i++) begin
      wr_msg(5'(i), 8'(8'h31 + 8'(i * 13)));
      mdl_msg[8*i +: 8] = 8'(8'h31 + 8'(i * 13));
    end
    rd_all(v);
    chk(v == mdl_msg, "R2 message readback", v, mdl_msg);
    rd_msg(5'd19, b);
    chk(b == mdl_msg[159:152], "R2 top byte", 160'(b), 160'(mdl_msg[159:152]));
    wr_msg(5'd25, 8'h5A);
    rd_msg(5'd25, b);
    chk(b == 8'h00, "R2 out-of-range address", 160'(b), 160'h0);
    rd_all(v);
    chk(v == mdl_msg, "R2 out-of-range write dropped", v, mdl_msg);

    // R9 / R7: reserved, DONE and POR bits written as 1
    wr_ctrl(8'hEE);
    rd_ctrl(b);
    chk(b == 8'h04, "R9 reserved and DONE not writable", 160'(b), 160'h04);
    wr_ctrl(8'h00);
    rd_ctrl(b);
    chk(b == 8'h00, "R7 POR cleared by 0", 160'(b), 160'h00);
    wr_ctrl(8'h04);
    rd_ctrl(b);
    chk(b == 8'h00, "R7 POR write 1 no effect", 160'(b), 160'h00);

    // R3 / R8 job with disturbing writes
    key_in = 128'h0123456789ABCDEF_FEDCBA9876543210;
    run_job(1'b1, "R3 digest first job");
    // R10 chained job on previous digest
    run_job(1'b0, "R10 chained digest");
    // R10 new key
    key_in = 128'hA5A5A5A5_00000000_FFFFFFFF_5A5A5A5A;
    run_job(1'b1, "R10 new key digest");

    // R6 clear
    wr_ctrl(8'h10);
    rd_ctrl(b);
    chk(b == 8'h02, "R6 CLEAR reads 0", 160'(b), 160'h02);
    rd_all(v);
    chk(v == '0, "R6 message zeroed", v, '0);
    mdl_msg = '0;
    run_job(1'b0, "R3 digest of zero message");

    // R2 writes accepted again after completion
    wr_msg(5'd0, 8'hC3);
    mdl_msg[7:0] = 8'hC3;
    rd_all(v);
    chk(v == mdl_msg, "R2 write after job", v, mdl_msg);

    finish_run();
  end
endmodule